// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps the bookkeeping for packets held in a receive byte FIFO without storing the bytes themselves. A receive MAC marks the start of each frame, reports every byte it pushes into the FIFO, and closes the frame with a completion record that carries a byte count and a 4-bit error code. The host side reads bytes from the oldest packet and can drop that packet with a discard command.

For the packet at the head of the queue the block presents a 16-bit status word. Bit 15 marks an empty queue or a head that is still arriving. Bits 14:11 hold a normalised error code. Bits 10:0 hold the byte count. Next to the word it drives diagnostic flags: status-queue full, byte-FIFO overrun, a sticky read underrun that also raises adapter failure, a receiving indicator and a one-cycle receive-complete pulse. An RX reset input clears all state synchronously.

Top module: `rxq_status_queue`

## Requirements
- R1: With an empty queue the status word is 0x8000. While the head packet is still arriving, bit 15 is 1, bits 14:11 are 0 and bits 10:0 give the bytes stored so far, saturating at 2047.
- R2: For a finished head, bit 15 is 0, bits 10:0 give the completion byte count, and bits 14:11 give the completion code when it is one of 1000 (overrun), 1011 (runt), 1100 (alignment), 1101 (CRC), 1001 (oversize) or 0010 (dribble, no error). Any other code shows as 0000. Bit 14 set means the packet is in error.
- R3: A completion byte count above MAX_LEN (1514) is reported with code 1001 and a count field of MAX_LEN, whatever code was supplied.
- R4: The status-overrun flag is high while DEPTH (8) packets are queued. A start of packet seen while it is high is ignored. The flag drops once a packet is discarded.
- R5: The FIFO-overrun flag rises when byte occupancy reaches FIFO_BYTES. A byte arriving while the FIFO is full is dropped, and a start of packet seen while the flag is high is ignored. The flag clears once occupancy falls to FIFO_BYTES-HYST or lower.
- R6: A byte read when the queue is empty, or when every stored byte of the head has been read, sets a sticky underrun flag and the adapter-failure output and changes nothing else. Only rst_ni or rx_reset_i clears it.
- R7: The receiving flag goes high the cycle after an accepted start of packet and low the cycle after its completion record. A start of packet seen while receiving is ignored, as are bytes and completions seen while not receiving.
- R8: A discard removes a finished head and releases its unread bytes from occupancy. A discard is ignored when the queue is empty or the head is still arriving. A read in the same cycle as an effective discard is ignored.
- R9: rx_complete_o pulses for one cycle whenever a finished packet becomes the head, either because the head completes or because a discard exposes an already finished packet.
- R10: rx_reset_i empties the queue, zeroes occupancy and clears every flag at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_reset_i | input | 1 | Synchronous clear of all receive state |
| sop_i | input | 1 | Start of a new frame from the MAC |
| wr_byte_i | input | 1 | One byte written into the FIFO |
| eop_i | input | 1 | Completion record valid |
| eop_len_i | input | 12 | Completion byte count |
| eop_code_i | input | 4 | Completion error code |
| rd_byte_i | input | 1 | Host reads one byte of the head packet |
| discard_i | input | 1 | Drop the head packet |
| rx_status_o | output | 16 | Status word of the head packet |
| rx_receiving_o | output | 1 | Frame being written into the FIFO |
| rx_status_ovr_o | output | 1 | Status queue full |
| rx_fifo_ovr_o | output | 1 | Byte FIFO full, reception blocked |
| rx_underrun_o | output | 1 | Sticky read-past-end flag |
| adapter_fail_o | output | 1 | Adapter failure raised by underrun |
| rx_complete_o | output | 1 | Finished packet became the head |

## Verification
Every output is a register, or a function of registers only, so the effect of an input held across a rising edge shows on the ports one cycle later. That holds for the status word, the flags and the receive-complete pulse, which comes from comparing the current head against state captured at that same edge. The bench drives inputs on the falling edge, advances its reference model at the rising edge, and compares all outputs on the next falling edge. Each result is therefore checked in exactly the cycle it is due, never a cycle early or late.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CNT_W = 12;
  localparam int LEN_W = 11;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam logic [3:0] CODE_NONE    = 4'b0000;
  localparam logic [3:0] CODE_OVERRUN = 4'b1000;
  localparam logic [3:0] CODE_RUNT    = 4'b1011;
  localparam logic [3:0] CODE_ALIGN   = 4'b1100;
  localparam logic [3:0] CODE_CRC     = 4'b1101;
  localparam logic [3:0] CODE_OVERSZ  = 4'b1001;
  localparam logic [3:0] CODE_DRIBBLE = 4'b0010;

  typedef struct packed {
    logic             done;
    logic [3:0]       code;
    logic [LEN_W-1:0] len;
    cnt_t             stored;
  } rxq_entry_t;

  function automatic logic [3:0] norm_code(input logic [3:0] c);
    case (c)
      CODE_OVERRUN, CODE_RUNT, CODE_ALIGN, CODE_CRC, CODE_OVERSZ, CODE_DRIBBLE: return c;
      default: return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rxq_queue.sv
module rxq_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             wr_i,
  input  logic             fin_i,
  input  logic [3:0]       fin_code_i,
  input  logic [LEN_W-1:0] fin_len_i,
  input  logic             pop_i,
  output rxq_entry_t       head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] head_q, tail_q, rx_idx;
  logic [CW-1:0] cnt_q;
  rxq_entry_t    mem_q [DEPTH];
  rxq_entry_t    mem_d [DEPTH];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  // entry currently being written by the MAC is the newest one
  assign rx_idx = (tail_q == '0) ? LAST : tail_q - PW'(1);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (push_i && tail_q == PW'(i)) begin
        mem_d[i] = '0;
      end else if (rx_idx == PW'(i)) begin
        if (wr_i) mem_d[i].stored = mem_q[i].stored + cnt_t'(1);
        if (fin_i) begin
          mem_d[i].done = 1'b1;
          mem_d[i].code = fin_code_i;
          mem_d[i].len  = fin_len_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem_q[head_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));

  p_no_push_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_pop_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (!empty_o && head_o.done));
endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
  import rxq_pkg::*;
#(
  parameter int CAP  = 2048,
  parameter int HYST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  input  logic free_i,
  input  cnt_t free_cnt_i,
  output logic full_o,
  output logic ovr_o
);
  localparam cnt_t CAP_C = cnt_t'(CAP);
  localparam cnt_t LOW_C = cnt_t'(CAP - HYST);

  cnt_t occ_q, occ_d;
  logic ovr_q, ovr_d;

  always_comb begin
    occ_d = occ_q + cnt_t'(inc_i) - cnt_t'(dec_i);
    if (free_i) occ_d = occ_d - free_cnt_i;
    if (occ_d == CAP_C)      ovr_d = 1'b1;
    else if (occ_d <= LOW_C) ovr_d = 1'b0;
    else                     ovr_d = ovr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      ovr_q <= 1'b0;
    end else if (clr_i) begin
      occ_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
      ovr_q <= ovr_d;
    end
  end

  assign full_o = (occ_q == CAP_C);
  assign ovr_o  = ovr_q;

  p_occ_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CAP_C);
  p_no_inc_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !full_o);
  p_free_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_i |-> (free_cnt_i <= occ_q));
endmodule

// File: rtl/rxq_status_fmt.sv
module rxq_status_fmt
  import rxq_pkg::*;
(
  input  logic       empty_i,
  input  rxq_entry_t head_i,
  output logic [15:0] status_o
);
  localparam cnt_t SAT = cnt_t'((1 << LEN_W) - 1);

  logic [LEN_W-1:0] live_len;

  assign live_len = (head_i.stored > SAT) ? LEN_W'(SAT) : head_i.stored[LEN_W-1:0];

  always_comb begin
    if (empty_i)           status_o = 16'h8000;
    else if (!head_i.done) status_o = {1'b1, 4'b0000, live_len};
    else                   status_o = {1'b0, head_i.code, head_i.len};
  end
endmodule

// File: rtl/rxq_status_queue.sv
module rxq_status_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int FIFO_BYTES = 2048,
  parameter int HYST       = 4,
  parameter int MAX_LEN    = 1514
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_reset_i,
  input  logic        sop_i,
  input  logic        wr_byte_i,
  input  logic        eop_i,
  input  logic [11:0] eop_len_i,
  input  logic [3:0]  eop_code_i,
  input  logic        rd_byte_i,
  input  logic        discard_i,
  output logic [15:0] rx_status_o,
  output logic        rx_receiving_o,
  output logic        rx_status_ovr_o,
  output logic        rx_fifo_ovr_o,
  output logic        rx_underrun_o,
  output logic        adapter_fail_o,
  output logic        rx_complete_o
);
  localparam logic [11:0] MAX_C = 12'(MAX_LEN);

  rxq_entry_t       head;
  logic             q_empty, q_full, occ_full, fovr;
  logic             recv_q, und_q, head_fin_q, popped_q;
  cnt_t             rd_cnt_q, unread;
  logic             accept_sop, wr_ok, eop_ok, pop, rd_in_range, rd_ok, rd_bad, head_fin;
  logic             oversize;
  logic [3:0]       fin_code;
  logic [LEN_W-1:0] fin_len;

  assign accept_sop  = sop_i & ~recv_q & ~q_full & ~fovr;
  assign wr_ok       = wr_byte_i & recv_q & ~occ_full;
  assign eop_ok      = eop_i & recv_q;
  assign pop         = discard_i & ~q_empty & head.done;
  assign rd_in_range = ~q_empty & (rd_cnt_q < head.stored);
  assign rd_ok       = rd_byte_i & ~pop & rd_in_range;
  assign rd_bad      = rd_byte_i & ~pop & ~rd_in_range;
  assign unread      = head.stored - rd_cnt_q;
  assign head_fin    = ~q_empty & head.done;

  assign oversize = (eop_len_i > MAX_C);
  assign fin_code = oversize ? CODE_OVERSZ : norm_code(eop_code_i);
  assign fin_len  = oversize ? LEN_W'(MAX_LEN) : eop_len_i[LEN_W-1:0];

  rxq_queue #(.DEPTH(DEPTH)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_reset_i),
    .push_i     (accept_sop),
    .wr_i       (wr_ok),
    .fin_i      (eop_ok),
    .fin_code_i (fin_code),
    .fin_len_i  (fin_len),
    .pop_i      (pop),
    .head_o     (head),
    .empty_o    (q_empty),
    .full_o     (q_full)
  );

  rxq_occupancy #(.CAP(FIFO_BYTES), .HYST(HYST)) u_occ (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (rx_reset_i),
    .inc_i      (wr_ok),
    .dec_i      (rd_ok),
    .free_i     (pop),
    .free_cnt_i (unread),
    .full_o     (occ_full),
    .ovr_o      (fovr)
  );

  rxq_status_fmt u_fmt (
    .empty_i  (q_empty),
    .head_i   (head),
    .status_o (rx_status_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      recv_q     <= 1'b0;
      und_q      <= 1'b0;
      rd_cnt_q   <= '0;
      head_fin_q <= 1'b0;
      popped_q   <= 1'b0;
    end else if (rx_reset_i) begin
      recv_q     <= 1'b0;
      und_q      <= 1'b0;
      rd_cnt_q   <= '0;
      head_fin_q <= 1'b0;
      popped_q   <= 1'b0;
    end else begin
      if (eop_ok)          recv_q <= 1'b0;
      else if (accept_sop) recv_q <= 1'b1;
      if (rd_bad) und_q <= 1'b1;
      if (pop)        rd_cnt_q <= '0;
      else if (rd_ok) rd_cnt_q <= rd_cnt_q + cnt_t'(1);
      head_fin_q <= head_fin;
      popped_q   <= pop;
    end
  end

  assign rx_receiving_o  = recv_q;
  assign rx_status_ovr_o = q_full;
  assign rx_fifo_ovr_o   = fovr;
  assign rx_underrun_o   = und_q;
  assign adapter_fail_o  = und_q;
  assign rx_complete_o   = head_fin & (~head_fin_q | popped_q);

  p_empty_status_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_empty |-> (rx_status_o == 16'h8000));
  p_sop_blocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sop_i && rx_status_ovr_o && !rx_receiving_o && !rx_reset_i) |=> !rx_receiving_o);
  p_und_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_underrun_o && !rx_reset_i) |=> rx_underrun_o);
  p_recv_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && rx_receiving_o) |=> !rx_receiving_o);
  p_cmpl_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_complete_o |-> !rx_status_o[15]);
  p_reset_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> (rx_status_o == 16'h8000 && !rx_underrun_o && !rx_fifo_ovr_o));
endmodule

// File: tb/rxq_status_queue_tb.sv
module rxq_status_queue_tb;
  localparam int DEPTH = 8;
  localparam int CAP   = 64;
  localparam int HYST  = 4;
  localparam int MAXL  = 1514;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        rx_reset_i, sop_i, wr_byte_i, eop_i, rd_byte_i, discard_i;
  logic [11:0] eop_len_i;
  logic [3:0]  eop_code_i;
  logic [15:0] rx_status_o;
  logic        rx_receiving_o, rx_status_ovr_o, rx_fifo_ovr_o;
  logic        rx_underrun_o, adapter_fail_o, rx_complete_o;

  always #5 clk_i = ~clk_i;

  rxq_status_queue #(.DEPTH(DEPTH), .FIFO_BYTES(CAP), .HYST(HYST), .MAX_LEN(MAXL)) u_dut (
    .clk_i, .rst_ni, .rx_reset_i, .sop_i, .wr_byte_i, .eop_i, .eop_len_i, .eop_code_i,
    .rd_byte_i, .discard_i, .rx_status_o, .rx_receiving_o, .rx_status_ovr_o,
    .rx_fifo_ovr_o, .rx_underrun_o, .adapter_fail_o, .rx_complete_o
  );

  int checks = 0;
  int fails  = 0;
  bit done_f = 0;

  // reference model
  bit m_done [DEPTH];
  int m_code [DEPTH];
  int m_len  [DEPTH];
  int m_st   [DEPTH];
  int m_head, m_cnt, m_occ, m_rdc;
  bit m_rcv, m_fovr, m_und, m_prevfin, m_popped;

  function automatic int exp_code(int len, int code);
    if (len > MAXL) return 9;
    case (code)
      8, 11, 12, 13, 9, 2: return code;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_status();
    if (m_cnt == 0) return 'h8000;
    if (!m_done[m_head]) return 'h8000 | ((m_st[m_head] > 2047) ? 2047 : m_st[m_head]);
    return (m_code[m_head] << 11) | m_len[m_head];
  endfunction

  function automatic bit fin_now();
    return (m_cnt > 0) && m_done[m_head];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) begin
      m_done[i] = 0; m_code[i] = 0; m_len[i] = 0; m_st[i] = 0;
    end
    m_head = 0; m_cnt = 0; m_occ = 0; m_rdc = 0;
    m_rcv = 0; m_fovr = 0; m_und = 0; m_prevfin = 0; m_popped = 0;
  endtask

  task automatic model_step(bit sop, bit wr, bit eop, int len, int code, bit rd, bit disc, bit rr);
    bit cur_fin, acc, wok, eok, pop, inr, rv, rb;
    int ri, ti, fr;
    if (rr) begin model_clear(); return; end
    cur_fin = fin_now();
    acc = sop && !m_rcv && (m_cnt < DEPTH) && !m_fovr;
    wok = wr && m_rcv && (m_occ != CAP);
    eok = eop && m_rcv;
    pop = disc && (m_cnt > 0) && m_done[m_head];
    inr = (m_cnt > 0) && (m_rdc < m_st[m_head]);
    rv  = rd && !pop && inr;
    rb  = rd && !pop && !inr;
    fr  = pop ? (m_st[m_head] - m_rdc) : 0;
    ri  = (m_head + m_cnt + DEPTH - 1) % DEPTH;
    ti  = (m_head + m_cnt) % DEPTH;
    if (wok) m_st[ri]++;
    if (eok) begin
      m_done[ri] = 1;
      m_code[ri] = exp_code(len, code);
      m_len[ri]  = (len > MAXL) ? MAXL : len;
    end
    if (acc) begin
      m_done[ti] = 0; m_code[ti] = 0; m_len[ti] = 0; m_st[ti] = 0;
    end
    if (pop) m_head = (m_head + 1) % DEPTH;
    m_cnt = m_cnt + int'(acc) - int'(pop);
    if (pop) m_rdc = 0; else if (rv) m_rdc++;
    m_occ = m_occ + int'(wok) - int'(rv) - fr;
    if (m_occ == CAP) m_fovr = 1; else if (m_occ <= CAP - HYST) m_fovr = 0;
    if (rb) m_und = 1;
    if (eok) m_rcv = 0; else if (acc) m_rcv = 1;
    m_popped  = pop;
    m_prevfin = cur_fin;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1/R2 status word", int'(rx_status_o), exp_status());
    chk("R4 status overrun", int'(rx_status_ovr_o), int'(m_cnt == DEPTH));
    chk("R5 fifo overrun", int'(rx_fifo_ovr_o), int'(m_fovr));
    chk("R6 underrun", int'(rx_underrun_o), int'(m_und));
    chk("R6 adapter failure", int'(adapter_fail_o), int'(m_und));
    chk("R7 receiving", int'(rx_receiving_o), int'(m_rcv));
    chk("R9 rx complete", int'(rx_complete_o), int'(fin_now() && (!m_prevfin || m_popped)));
  endtask

  task automatic drive(bit sop, bit wr, bit eop, int len, int code, bit rd, bit disc, bit rr);
    sop_i = sop; wr_byte_i = wr; eop_i = eop; eop_len_i = 12'(len); eop_code_i = 4'(code);
    rd_byte_i = rd; discard_i = disc; rx_reset_i = rr;
    @(posedge clk_i);
    model_step(sop, wr, eop, len, code, rd, disc, rr);
    @(negedge clk_i);
    check_all();
  endtask

  task automatic idle(); drive(0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic rxrst(); drive(0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic rd1(); drive(0, 0, 0, 0, 0, 1, 0, 0); endtask
  task automatic disc1(); drive(0, 0, 0, 0, 0, 0, 1, 0); endtask

  task automatic pkt(int nbytes, int len, int code);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < nbytes; i++) drive(0, 1, 0, 0, 0, 0, 0, 0);
    drive(0, 0, 1, len, code, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    rx_reset_i = 0; sop_i = 0; wr_byte_i = 0; eop_i = 0; rd_byte_i = 0; discard_i = 0;
    eop_len_i = '0; eop_code_i = '0;
    model_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();
    chk("R1 reset status", int'(rx_status_o), 'h8000);

    // R4: fill the status queue, ninth frame must be ignored
    for (int p = 0; p < DEPTH; p++) pkt(3, 3, 13);
    chk("R2 crc head", int'(rx_status_o), 'h6803);
    chk("R4 queue full", int'(rx_status_ovr_o), 1);
    pkt(2, 2, 0);
    chk("R4 ninth frame ignored", int'(rx_receiving_o), 0);
    disc1();
    chk("R4 flag drops after discard", int'(rx_status_ovr_o), 0);
    rxrst();

    // R3: oversize
    pkt(4, 2000, 13);
    chk("R3 oversize status", int'(rx_status_o), 'h4DEA);
    // R6: reads then overread
    for (int i = 0; i < 4; i++) rd1();
    chk("R6 no underrun yet", int'(rx_underrun_o), 0);
    rd1();
    chk("R6 underrun set", int'(rx_underrun_o), 1);
    disc1();
    idle();
    chk("R6 underrun sticky", int'(rx_underrun_o), 1);

    // R8: discard of incomplete head ignored
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0, 0, 0, 0);
    disc1();
    chk("R8 discard ignored on open head", int'(rx_status_o), 'h8002);
    rxrst();
    chk("R10 status cleared", int'(rx_status_o), 'h8000);
    chk("R10 underrun cleared", int'(rx_underrun_o), 0);

    // R5: byte FIFO overrun and hysteresis
    pkt(CAP + 3, CAP, 2);
    chk("R5 fifo full", int'(rx_fifo_ovr_o), 1);
    chk("R2 dribble code", int'(rx_status_o), 'h1000 | CAP);
    drive(1, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 sop ignored on overrun", int'(rx_receiving_o), 0);
    for (int i = 0; i < HYST - 1; i++) rd1();
    chk("R5 still set", int'(rx_fifo_ovr_o), 1);
    rd1();
    chk("R5 cleared", int'(rx_fifo_ovr_o), 0);
    disc1();
    rxrst();

    // random phase
    for (int c = 0; c < 5000; c++) begin
      bit s, w, e, r, d, x;
      int ln, cd;
      s  = ($urandom_range(0, 9) == 0);
      w  = ($urandom_range(0, 1) == 0);
      e  = ($urandom_range(0, 11) == 0);
      r  = ($urandom_range(0, 3) == 0);
      d  = ($urandom_range(0, 9) == 0);
      x  = ($urandom_range(0, 149) == 0);
      ln = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1515, 4095)) : int'($urandom_range(0, 1514));
      cd = int'($urandom_range(0, 15));
      drive(s, w, e, ln, cd, r, d, x);
    end

    done_f = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done_f) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule